// File: doc/BRIEF.md
# Real-Time Clock Register File

This block keeps a binary calendar (seconds, minutes, hours, day of week, day of month, month and a two-digit year) and presents it, together with four byte-wide control/status registers, on a simple read/write register bus. A one-hertz tick starts an update sequencer. The sequencer ripples the carry one calendar field per clock cycle. While a ripple is running, the update-in-progress flag is raised in control register A. A load port presets the whole calendar in one cycle, so the time can be set from outside the bus.

The register bus is decoded on address bits [4:1], which gives sixteen byte slots. Odd slots return their byte in bits 23:16 of the read word and even slots in bits 7:0. The reporting mode has two settings. True-date mode reports the counted date. Legacy mode pins the reported year to 82. In legacy mode, dates in a leap year are also shifted onto the day a non-leap calendar would show. Two strobes, set-valid and set-invalid, force fixed configuration bits and the valid-time flag. Rate, alarm, interrupt and square-wave fields are stored where writable and drive nothing.

The sequencer has the states CS_IDLE, CS_SEC, CS_MIN, CS_HOUR, CS_DAY, CS_MON and CS_YEAR. It moves through the following transitions:
- CS_IDLE goes to CS_SEC on a tick.
- Each field state moves to the next field when its field wraps, and returns to CS_IDLE when it does not.
- CS_YEAR always returns to CS_IDLE.
- A calendar load forces CS_IDLE from any state.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the control registers A, B, C and D all read 0x00 and legacy mode is selected, so slot 9 (year) reads 82. The calendar resets to year 0, month 1, day 1, day of week 0, 00:00:00.
- R2: A read with bus_rd high returns, in bus_rdata from the next clock, the byte of slot bus_addr[4:1]. Odd slots place the byte in bits 23:16 and even slots in bits 7:0. All other bits are 0. The slot map is: 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 day of month, 8 month, 9 year, 10 to 13 control A to D.
- R3: Each tick advances seconds. Seconds and minutes wrap 59 to 0, and hours wrap 23 to 0, each carrying into the next field. Day of week advances with the day and wraps 6 to 0. Month wraps 12 to 1, and year wraps 99 to 0.
- R4: Month lengths are 31, with 30 for months 4, 6, 9 and 11. February has 29 days when the two-digit year is divisible by 4 and 28 otherwise.
- R5: Bit 7 of control A reads 1 while the sequencer is out of CS_IDLE. A tick that arrives while it is out of CS_IDLE is dropped.
- R6: Writes to control A store bits 6:0. Bit 7 is never stored.
- R7: Writes to control B store only the bits under mask 0x87. Bits 6:3 keep their value.
- R8: Writes to control C are ignored, and C reads 0x00. Control D stores and returns only bit 7, and its bits 6:0 read 0.
- R9: In legacy mode the year reads 82. In true-date mode it reads the counted year.
- R10: In legacy mode, when the counted year is divisible by 4 and the month is after February, the day of month is reported one higher. If that passes the non-leap month length, the first day of the following month is reported instead, and December wraps to January.
- R11: In legacy mode in such a year, February 29 reports as month 3, day 1. Earlier dates are unchanged. Years not divisible by 4, and true-date mode, are never shifted.
- R12: A set_valid strobe ORs 2 into the divider field (control A bits 6:4), sets control B bits 2 and 1, and sets control D bit 7. The effect is visible on the next read.
- R13: A set_invalid strobe clears only control D bit 7. It wins over set_valid in the same cycle.
- R14: Bus writes to time slots 0 to 9 are ignored. Alarm slots 1, 3 and 5 and unused slots 14 and 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-hertz update strobe, one cycle wide |
| mode_load | input | 1 | Loads mode_std into the mode register |
| mode_std | input | 1 | 1 selects true-date mode, 0 selects legacy mode |
| cal_load | input | 1 | Loads the calendar from the ld_* inputs |
| ld_year | input | 7 | Year to load, 0 to 99 |
| ld_month | input | 4 | Month to load, 1 to 12 |
| ld_day | input | 5 | Day of month to load |
| ld_dow | input | 3 | Day of week to load, 0 to 6 |
| ld_hour | input | 5 | Hour to load, 0 to 23 |
| ld_min | input | 6 | Minute to load |
| ld_sec | input | 6 | Second to load |
| set_valid | input | 1 | Forces the valid configuration bits |
| set_invalid | input | 1 | Clears the valid-time flag |
| bus_addr | input | 4 | Byte address bits [4:1], the slot index |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 32 | Registered read word |

## Verification
The hardest situation to bring about is a read that lands inside a carry ripple, since a ripple lasts only a few clock cycles after a tick. The bench first loads 23:59:59 so that the ripple spans several states. It then issues the read of control A on the cycle right after the tick and raises a second tick two cycles later, while the sequencer is still busy. The legacy-mode date shifts depend on dates that a counter would need months of ticks to reach, so the bench presets each leap-year corner through the calendar load port and reads it back in both modes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        CS_IDLE, CS_SEC, CS_MIN, CS_HOUR, CS_DAY, CS_MON, CS_YEAR
    } cal_state_e;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] day;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{year: 7'd0, month: 4'd1, day: 5'd1, dow: 3'd0,
                                   hour: 5'd0, minute: 6'd0, sec: 6'd0};

    // slot indices decoded from the bus address
    localparam logic [3:0] SLOT_SEC  = 4'd0;
    localparam logic [3:0] SLOT_MIN  = 4'd2;
    localparam logic [3:0] SLOT_HOUR = 4'd4;
    localparam logic [3:0] SLOT_DOW  = 4'd6;
    localparam logic [3:0] SLOT_DOM  = 4'd7;
    localparam logic [3:0] SLOT_MON  = 4'd8;
    localparam logic [3:0] SLOT_YEAR = 4'd9;
    localparam logic [3:0] SLOT_CTLA = 4'd10;
    localparam logic [3:0] SLOT_CTLB = 4'd11;
    localparam logic [3:0] SLOT_CTLC = 4'd12;
    localparam logic [3:0] SLOT_CTLD = 4'd13;

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd2:                    return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal.sv
module rtc_cal
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cal_t load_val,
    output cal_t cal,
    output logic busy
);
    cal_state_e state_q, state_n;
    cal_t       cal_q;

    logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

    always_comb begin
        sec_wrap  = (cal_q.sec == 6'd59);
        min_wrap  = (cal_q.minute == 6'd59);
        hour_wrap = (cal_q.hour == 5'd23);
        day_wrap  = (cal_q.day >= month_len(cal_q.month, cal_q.year[1:0] == 2'b00));
        mon_wrap  = (cal_q.month >= 4'd12);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        if (load) begin
            state_n = CS_IDLE;
        end else begin
            unique case (state_q)
                CS_IDLE: if (tick) state_n = CS_SEC;
                CS_SEC:  state_n = sec_wrap  ? CS_MIN  : CS_IDLE;
                CS_MIN:  state_n = min_wrap  ? CS_HOUR : CS_IDLE;
                CS_HOUR: state_n = hour_wrap ? CS_DAY  : CS_IDLE;
                CS_DAY:  state_n = day_wrap  ? CS_MON  : CS_IDLE;
                CS_MON:  state_n = mon_wrap  ? CS_YEAR : CS_IDLE;
                CS_YEAR: state_n = CS_IDLE;
                default: state_n = CS_IDLE;
            endcase
        end
    end

    // calendar fields, one field per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= CAL_RESET;
        end else if (load) begin
            cal_q <= load_val;
        end else begin
            unique case (state_q)
                CS_SEC:  cal_q.sec    <= sec_wrap  ? 6'd0 : cal_q.sec + 6'd1;
                CS_MIN:  cal_q.minute <= min_wrap  ? 6'd0 : cal_q.minute + 6'd1;
                CS_HOUR: cal_q.hour   <= hour_wrap ? 5'd0 : cal_q.hour + 5'd1;
                CS_DAY: begin
                    cal_q.dow <= (cal_q.dow >= 3'd6) ? 3'd0 : cal_q.dow + 3'd1;
                    cal_q.day <= day_wrap ? 5'd1 : cal_q.day + 5'd1;
                end
                CS_MON:  cal_q.month <= mon_wrap ? 4'd1 : cal_q.month + 4'd1;
                CS_YEAR: cal_q.year  <= (cal_q.year >= 7'd99) ? 7'd0 : cal_q.year + 7'd1;
                default: ;
            endcase
        end
    end

    assign cal  = cal_q;
    assign busy = (state_q != CS_IDLE);

endmodule

// File: rtl/rtc_view.sv
module rtc_view
    import rtc_pkg::*;
#(
    parameter int LEGACY_YEAR = 82
) (
    input  logic       legacy,
    input  logic [6:0] year,
    input  logic [3:0] month,
    input  logic [4:0] day,
    output logic [3:0] rep_month,
    output logic [4:0] rep_day,
    output logic [7:0] rep_year
);
    logic       leap;
    logic [5:0] day_p1;

    always_comb begin
        leap      = (year[1:0] == 2'b00);
        day_p1    = {1'b0, day} + 6'd1;
        rep_month = month;
        rep_day   = day;
        rep_year  = legacy ? 8'(LEGACY_YEAR) : {1'b0, year};
        if (legacy && leap) begin
            if (month > 4'd2) begin
                if (day_p1 > {1'b0, month_len(month, 1'b0)}) begin
                    rep_month = (month >= 4'd12) ? 4'd1 : month + 4'd1;
                    rep_day   = 5'd1;
                end else begin
                    rep_day   = day_p1[4:0];
                end
            end else if (month == 4'd2 && day == 5'd29) begin
                rep_month = 4'd3;
                rep_day   = 5'd1;
            end
        end
    end

endmodule

// File: rtl/rtc_csr.sv
module rtc_csr
    import rtc_pkg::*;
#(
    parameter logic [2:0] DV_VALID = 3'd2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] slot,
    input  logic [7:0] wdata,
    input  logic       set_valid,
    input  logic       set_invalid,
    output logic [6:0] ctl_a,
    output logic [7:0] ctl_b,
    output logic       ctl_d_vrt
);
    localparam logic [7:0] B_WMASK = 8'h87;

    logic [6:0] a_q, a_n;
    logic [7:0] b_q, b_n;
    logic       d_q, d_n;

    always_comb begin
        a_n = a_q;
        b_n = b_q;
        d_n = d_q;
        if (wr_en) begin
            unique case (slot)
                SLOT_CTLA: a_n = wdata[6:0];
                SLOT_CTLB: b_n = (b_q & ~B_WMASK) | (wdata & B_WMASK);
                SLOT_CTLD: d_n = wdata[7];
                default: ;
            endcase
        end
        if (set_valid) begin
            a_n[6:4] = a_n[6:4] | DV_VALID;
            b_n[2:1] = 2'b11;
            d_n      = 1'b1;
        end
        if (set_invalid) d_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            d_q <= 1'b0;
        end else begin
            a_q <= a_n;
            b_q <= b_n;
            d_q <= d_n;
        end
    end

    assign ctl_a     = a_q;
    assign ctl_b     = b_q;
    assign ctl_d_vrt = d_q;

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int         ADDR_MSB    = 4,
    parameter int         RDATA_W     = 32,
    parameter int         ODD_LANE    = 16,
    parameter int         LEGACY_YEAR = 82,
    parameter logic [2:0] DV_VALID    = 3'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               mode_load,
    input  logic               mode_std,
    input  logic               cal_load,
    input  logic [6:0]         ld_year,
    input  logic [3:0]         ld_month,
    input  logic [4:0]         ld_day,
    input  logic [2:0]         ld_dow,
    input  logic [4:0]         ld_hour,
    input  logic [5:0]         ld_min,
    input  logic [5:0]         ld_sec,
    input  logic               set_valid,
    input  logic               set_invalid,
    input  logic [ADDR_MSB:1]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    output logic [RDATA_W-1:0] bus_rdata
);
    localparam int PAD_W = RDATA_W - 8;

    cal_t       cal_q, cal_ld;
    logic       busy;
    logic       mode_std_q;
    logic [3:0] slot;
    logic [3:0] rep_month;
    logic [4:0] rep_day;
    logic [7:0] rep_year;
    logic [6:0] ctl_a;
    logic [7:0] ctl_b;
    logic       ctl_d_vrt;
    logic [7:0] rd_byte;
    logic [RDATA_W-1:0] rd_word;

    assign slot   = bus_addr[4:1];
    assign cal_ld = '{year: ld_year, month: ld_month, day: ld_day, dow: ld_dow,
                      hour: ld_hour, minute: ld_min, sec: ld_sec};

    rtc_cal u_cal (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cal_load),
        .load_val(cal_ld), .cal(cal_q), .busy(busy)
    );

    rtc_view #(.LEGACY_YEAR(LEGACY_YEAR)) u_view (
        .legacy(!mode_std_q), .year(cal_q.year), .month(cal_q.month),
        .day(cal_q.day), .rep_month(rep_month), .rep_day(rep_day),
        .rep_year(rep_year)
    );

    rtc_csr #(.DV_VALID(DV_VALID)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .slot(slot),
        .wdata(bus_wdata), .set_valid(set_valid), .set_invalid(set_invalid),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_d_vrt(ctl_d_vrt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mode_std_q <= 1'b0;
        else if (mode_load) mode_std_q <= mode_std;
    end

    always_comb begin
        case (slot)
            SLOT_SEC:  rd_byte = {2'b0, cal_q.sec};
            SLOT_MIN:  rd_byte = {2'b0, cal_q.minute};
            SLOT_HOUR: rd_byte = {3'b0, cal_q.hour};
            SLOT_DOW:  rd_byte = {5'b0, cal_q.dow};
            SLOT_DOM:  rd_byte = {3'b0, rep_day};
            SLOT_MON:  rd_byte = {4'b0, rep_month};
            SLOT_YEAR: rd_byte = rep_year;
            SLOT_CTLA: rd_byte = {busy, ctl_a};
            SLOT_CTLB: rd_byte = ctl_b;
            SLOT_CTLD: rd_byte = {ctl_d_vrt, 7'b0};
            default:   rd_byte = 8'h00;
        endcase
        rd_word = {{PAD_W{1'b0}}, rd_byte};
        if (slot[0]) rd_word = rd_word << ODD_LANE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic [4:1]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        set_valid,
    input logic        set_invalid,
    input logic        cal_load,
    input logic        busy,
    input logic [5:0]  sec,
    input logic [5:0]  minute,
    input logic [4:0]  hour,
    input logic [2:0]  dow,
    input logic [7:0]  ctl_b,
    input logic        ctl_d_vrt,
    input logic        mode_std_q
);
    a_r2_lanes_clean: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[31:24] == 8'h0 && bus_rdata[15:8] == 8'h0 &&
                    (bus_rdata[23:16] == 8'h0 || bus_rdata[7:0] == 8'h0)));

    a_r3_field_ranges: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_load |=> (sec <= 6'd59 && minute <= 6'd59 && hour <= 5'd23 && dow <= 3'd6));

    a_r5_sec_only_in_ripple: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cal_load) |=> $stable(sec));

    a_r7_b_hidden_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ctl_b[6:3]));

    a_r8_d_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd13) |=> (bus_rdata[22:16] == 7'h0));

    a_r9_legacy_year: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd9 && !mode_std_q) |=> (bus_rdata[23:16] == 8'd82));

    a_r12_valid_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && !set_invalid) |=> (ctl_d_vrt && ctl_b[2:1] == 2'b11));

    a_r13_invalid_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_invalid |=> !ctl_d_vrt);

endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .set_valid(set_valid), .set_invalid(set_invalid),
    .cal_load(cal_load), .busy(busy), .sec(cal_q.sec), .minute(cal_q.minute),
    .hour(cal_q.hour), .dow(cal_q.dow), .ctl_b(ctl_b), .ctl_d_vrt(ctl_d_vrt),
    .mode_std_q(mode_std_q)
);

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, mode_load = 1'b0, mode_std = 1'b0, cal_load = 1'b0;
    logic [6:0]  ld_year = '0;
    logic [3:0]  ld_month = '0;
    logic [4:0]  ld_day = '0;
    logic [2:0]  ld_dow = '0;
    logic [4:0]  ld_hour = '0;
    logic [5:0]  ld_min = '0, ld_sec = '0;
    logic        set_valid = 1'b0, set_invalid = 1'b0;
    logic [4:1]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regfile u_rtc_regfile (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_load(mode_load),
        .mode_std(mode_std), .cal_load(cal_load), .ld_year(ld_year),
        .ld_month(ld_month), .ld_day(ld_day), .ld_dow(ld_dow),
        .ld_hour(ld_hour), .ld_min(ld_min), .ld_sec(ld_sec),
        .set_valid(set_valid), .set_invalid(set_invalid),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] lane(input int slot, input logic [7:0] b);
        return slot[0] ? {8'h0, b, 16'h0} : {24'h0, b};
    endfunction

    task automatic check_word(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input int slot, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = 4'(slot);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        check_word($sformatf("%s slot %0d", tag, slot), bus_rdata, lane(slot, exp));
    endtask

    task automatic wr(input int slot, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = 4'(slot);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic set_mode(input logic std);
        @(negedge clk);
        mode_std = std; mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic load_cal(input int y, input int mo, input int d, input int w,
                            input int h, input int mi, input int s);
        @(negedge clk);
        ld_year = 7'(y); ld_month = 4'(mo); ld_day = 5'(d); ld_dow = 3'(w);
        ld_hour = 5'(h); ld_min = 6'(mi); ld_sec = 6'(s);
        cal_load = 1'b1;
        @(negedge clk);
        cal_load = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(10, 8'h00, "R1 ctl A");
        rd_chk(11, 8'h00, "R1 ctl B");
        rd_chk(12, 8'h00, "R1 ctl C");
        rd_chk(13, 8'h00, "R1 ctl D");
        rd_chk(9, 8'd82, "R1 legacy year");
        rd_chk(8, 8'd1, "R1 month");
        rd_chk(7, 8'd1, "R1 day");
        rd_chk(0, 8'd0, "R1 sec");
    endtask

    task automatic t_uip();
        load_cal(5, 1, 10, 2, 23, 59, 59);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        bus_addr = 4'd10;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check_word("R5 uip while busy", bus_rdata, 32'h80);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (10) @(negedge clk);
        rd_chk(0, 8'd0, "R5 dropped tick sec");
        rd_chk(4, 8'd0, "R3 hour wrap");
        rd_chk(6, 8'd3, "R3 dow advance");
        rd_chk(10, 8'h00, "R5 uip clear");
    endtask

    task automatic t_lanes();
        set_mode(1'b1);
        load_cal(37, 7, 19, 3, 14, 25, 48);
        rd_chk(0, 8'd48, "R2 sec");
        rd_chk(2, 8'd25, "R2 min");
        rd_chk(4, 8'd14, "R2 hour");
        rd_chk(6, 8'd3, "R2 dow");
        rd_chk(7, 8'd19, "R2 dom");
        rd_chk(8, 8'd7, "R2 month");
        rd_chk(9, 8'd37, "R9 std year");
        for (int s = 1; s < 6; s += 2) rd_chk(s, 8'h00, "R14 alarm slot");
        rd_chk(14, 8'h00, "R14 unused");
        rd_chk(15, 8'h00, "R14 unused");
        wr(0, 8'h11);
        wr(9, 8'h05);
        rd_chk(0, 8'd48, "R14 sec write ignored");
        rd_chk(9, 8'd37, "R14 year write ignored");
    endtask

    task automatic t_rollover();
        set_mode(1'b1);
        load_cal(10, 3, 5, 1, 10, 20, 30);
        do_tick();
        rd_chk(0, 8'd31, "R3 sec step");
        rd_chk(2, 8'd20, "R3 min hold");
        load_cal(24, 2, 28, 6, 23, 59, 59);
        do_tick();
        rd_chk(7, 8'd29, "R4 leap feb 29");
        rd_chk(8, 8'd2, "R4 leap month");
        rd_chk(6, 8'd0, "R3 dow wrap");
        load_cal(23, 2, 28, 2, 23, 59, 59);
        do_tick();
        rd_chk(7, 8'd1, "R4 nonleap feb end");
        rd_chk(8, 8'd3, "R4 nonleap month");
        load_cal(10, 4, 30, 4, 23, 59, 59);
        do_tick();
        rd_chk(8, 8'd5, "R4 30-day month");
        load_cal(99, 12, 31, 5, 23, 59, 59);
        do_tick();
        rd_chk(9, 8'd0, "R3 year wrap");
        rd_chk(8, 8'd1, "R3 month wrap");
        rd_chk(7, 8'd1, "R3 day wrap");
    endtask

    task automatic t_csr();
        wr(10, 8'hFF);
        rd_chk(10, 8'h7F, "R6 A mask");
        wr(10, 8'h25);
        rd_chk(10, 8'h25, "R6 A value");
        wr(11, 8'hFF);
        rd_chk(11, 8'h87, "R7 B mask");
        wr(11, 8'h00);
        rd_chk(11, 8'h00, "R7 B clear");
        wr(12, 8'hFF);
        rd_chk(12, 8'h00, "R8 C ignored");
        wr(13, 8'hFF);
        rd_chk(13, 8'h80, "R8 D bit7");
        wr(13, 8'h7F);
        rd_chk(13, 8'h00, "R8 D low bits");
    endtask

    task automatic t_legacy();
        set_mode(1'b0);
        load_cal(24, 3, 31, 0, 8, 0, 0);
        rd_chk(8, 8'd4, "R10 mar31 month");
        rd_chk(7, 8'd1, "R10 mar31 day");
        rd_chk(9, 8'd82, "R9 legacy year");
        load_cal(24, 6, 10, 0, 8, 0, 0);
        rd_chk(7, 8'd11, "R10 day plus one");
        load_cal(24, 12, 31, 0, 8, 0, 0);
        rd_chk(8, 8'd1, "R10 dec wrap month");
        rd_chk(7, 8'd1, "R10 dec wrap day");
        load_cal(24, 2, 29, 0, 8, 0, 0);
        rd_chk(8, 8'd3, "R11 feb29 month");
        rd_chk(7, 8'd1, "R11 feb29 day");
        load_cal(24, 2, 28, 0, 8, 0, 0);
        rd_chk(7, 8'd28, "R11 feb28 unchanged");
        load_cal(23, 3, 31, 0, 8, 0, 0);
        rd_chk(7, 8'd31, "R11 nonleap unchanged");
        set_mode(1'b1);
        load_cal(24, 3, 31, 0, 8, 0, 0);
        rd_chk(7, 8'd31, "R11 std unchanged");
        rd_chk(9, 8'd24, "R9 std year");
    endtask

    task automatic t_valid();
        wr(10, 8'h50);
        wr(11, 8'h00);
        wr(13, 8'h00);
        @(negedge clk);
        set_valid = 1'b1;
        @(negedge clk);
        set_valid = 1'b0;
        rd_chk(10, 8'h70, "R12 divider OR");
        rd_chk(11, 8'h06, "R12 B bits");
        rd_chk(13, 8'h80, "R12 valid set");
        @(negedge clk);
        set_invalid = 1'b1;
        @(negedge clk);
        set_invalid = 1'b0;
        rd_chk(13, 8'h00, "R13 invalid clears");
        rd_chk(11, 8'h06, "R13 B kept");
        rd_chk(10, 8'h70, "R13 A kept");
        @(negedge clk);
        set_valid = 1'b1; set_invalid = 1'b1;
        @(negedge clk);
        set_valid = 1'b0; set_invalid = 1'b0;
        rd_chk(13, 8'h00, "R13 invalid wins");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_uip();
        t_lanes();
        t_rollover();
        t_csr();
        t_legacy();
        t_valid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule